// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the slave end of a synchronous three-wire link. The link has an enable line, a serial clock and one shared data line. Through it a host can read and write a bank of eight clock registers and a 24-byte scratch RAM. Seven of the clock registers belong to an external timekeeping counter, which the block reaches through a parallel port: the current time comes in as a packed vector, and updates go out as a byte mask with matching data. The eighth clock register is a control byte that lives in the block. Its top bit is a write-protect flag.

Each transfer opens with a command byte, sent least-significant bit first:

| Bit | Meaning |
|---|---|
| 0 | Direction: 1 = read, 0 = write |
| 5..1 | Address |
| 6 | Space: 1 = RAM, 0 = clock registers |
| 7 | Must be 1 for the transfer to proceed |

Address 31 selects burst mode, which starts at location 0 and steps through the selected space. The block drives the data line only while a read is in its data phase. Driving is controlled by an output-enable, so the pad forms a tri-state buffer.

All logic runs on a fast system clock. The serial clock, the enable line and the data input each pass through two-flop synchronisers. The serial clock period must therefore be at least about four system clocks.

Top module: `serial_reg_slave`

## Requirements
- R1: While the synchronised enable line is low, `sdio_oe` is 0 and no transfer is in progress. Dropping the enable line mid-byte discards the partial byte.
- R2: Inputs are sampled on rising serial-clock edges and every byte is sent LSB first. On a read, `sdio_oe` rises and data bit 0 appears after the first falling edge that follows the last command bit. Each later falling edge presents the next bit.
- R3: If command bit 7 is 0, the rest of the transfer is ignored. Nothing is written and the data line is never driven.
- R4: A single-byte RAM write (command bits 6=1, 0=0, address in bits 5..1) stores the byte, and a later single-byte RAM read returns it.
- R5: A single-byte write to clock address 0..6 produces a one-cycle pulse on `tk_wr_mask_o`. Only bit `address` is set, and the byte appears at byte lane `address` of `tk_wr_data_o`. A read of that address returns byte lane `address` of `tk_time_i`.
- R6: A RAM burst (address 31) writes each completed byte in turn from byte 0. An enable drop keeps the bytes already completed. A RAM burst read that runs past byte 23 wraps to byte 0.
- R7: A clock burst write commits only when all eight bytes have arrived. The commit is a single pulse with `tk_wr_mask_o` = 7'h7F carrying bytes 0..6, and byte 7 loads the control register. A shorter burst changes nothing. A clock burst read returns registers 0..7 and then wraps.
- R8: While control bit 7 is 1, writes to RAM and to clock registers 0..6 are dropped, in single-byte mode and in burst mode alike. The control register itself can still be written.
- R9: Reads of the control register (clock address 7) return bits 6..0 as 0.
- R10: Reads of clock addresses 8..30 and RAM addresses 24..30 return 8'h00.
- R11: In a single-byte read, clocks after the eighth data bit repeat the same byte for as long as the enable line stays high.
- R12: In a single-byte write, clocks after the data byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Transfer enable line (asynchronous) |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output value |
| sdio_oe | output | 1 | Data line drive enable |
| tk_time_i | input | 56 | Current time registers 0..6, register n in byte lane n |
| tk_wr_mask_o | output | 7 | One-cycle update strobe per time register |
| tk_wr_data_o | output | 56 | Update data, register n in byte lane n |

## Verification
The bench targets the following corner cases and the failure each would expose:

- **Enable dropped mid-byte.** A design that keeps partial state would commit a stray RAM byte, or keep driving the line after the enable goes low.
- **Command with bit 7 clear.** A design that ignores bit 7 would overwrite RAM byte 5.
- **Clock burst cut short after five bytes.** A design that commits as bytes arrive would pulse the time port.
- **Clock burst while write-protect is set.** A design with a protect check that is too wide would fail to clear the flag. One with a check that is too narrow would overwrite the time.
- **Long RAM burst read.** A design without the wrap would return zeros at byte 24 instead of byte 0 again.
- **Extra clocks after a single write.** A design that keeps advancing would spill into the next RAM byte.
- **Extra clocks after a single read.** A design that keeps advancing would step to the next byte instead of repeating the same one.

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
  parameter int RAM_BYTES = 24,
  parameter int CLK_REGS  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_i,
  input  logic                      sck_i,
  input  logic                      sdio_i,
  output logic                      sdio_o,
  output logic                      sdio_oe,
  input  logic [8*(CLK_REGS-1)-1:0] tk_time_i,
  output logic [CLK_REGS-2:0]       tk_wr_mask_o,
  output logic [8*(CLK_REGS-1)-1:0] tk_wr_data_o
);
  localparam int AW = 5;
  localparam int TREGS = CLK_REGS - 1;
  localparam logic [AW-1:0] BURST    = '1;
  localparam logic [AW-1:0] RAM_LAST = AW'(RAM_BYTES - 1);
  localparam logic [AW-1:0] CLK_LAST = AW'(CLK_REGS - 1);

  typedef enum logic [1:0] {P_CMD, P_WR, P_RD, P_IGN} phase_t;

  logic [2:0] sel_q, sck_q;
  logic [1:0] sdi_q;
  logic       sel_s, sck_rise, sck_fall, sdi;

  phase_t        phase;
  logic [2:0]    cnt, tcnt;
  logic [7:0]    sh, txsh, rd_byte;
  logic          space, burst, wp;
  logic [AW-1:0] idx;
  logic [7:0]    bbuf [CLK_REGS];
  logic [7:0]    ram  [RAM_BYTES];
  logic [7:0]    in_byte;

  assign sel_s    = sel_q[1];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign sdi      = sdi_q[1];
  assign in_byte  = {sdi, sh[7:1]};
  assign sdio_o   = txsh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      sel_q <= {sel_q[1:0], sel_i};
      sck_q <= {sck_q[1:0], sck_i};
      sdi_q <= {sdi_q[0], sdio_i};
    end

  always_comb begin
    rd_byte = '0;
    if (space) begin
      if (idx <= RAM_LAST) rd_byte = ram[idx];
    end else if (idx == CLK_LAST) begin
      rd_byte = {wp, 7'b0};
    end else begin
      for (int i = 0; i < TREGS; i++)
        if (idx == AW'(i)) rd_byte = tk_time_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase        <= P_CMD;
      cnt          <= '0;
      tcnt         <= '0;
      sh           <= '0;
      txsh         <= '0;
      space        <= 1'b0;
      burst        <= 1'b0;
      wp           <= 1'b0;
      idx          <= '0;
      sdio_oe      <= 1'b0;
      tk_wr_mask_o <= '0;
      tk_wr_data_o <= '0;
      for (int i = 0; i < CLK_REGS; i++) bbuf[i] <= '0;
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
    end else begin
      tk_wr_mask_o <= '0;
      if (!sel_s) begin
        phase   <= P_CMD;
        cnt     <= '0;
        tcnt    <= '0;
        sdio_oe <= 1'b0;
      end else begin
        if (sck_rise) begin
          case (phase)
            P_CMD: begin
              sh  <= in_byte;
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                if (!in_byte[7]) begin
                  phase <= P_IGN;
                end else begin
                  space <= in_byte[6];
                  burst <= (in_byte[5:1] == BURST);
                  idx   <= (in_byte[5:1] == BURST) ? '0 : in_byte[5:1];
                  phase <= in_byte[0] ? P_RD : P_WR;
                end
              end
            end
            P_WR: begin
              sh  <= in_byte;
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                if (space) begin
                  if (idx <= RAM_LAST && !wp) ram[idx] <= in_byte;
                  if (burst && idx < RAM_LAST) idx <= idx + 1'b1;
                  else phase <= P_IGN;
                end else if (burst) begin
                  bbuf[idx[$clog2(CLK_REGS)-1:0]] <= in_byte;
                  if (idx == CLK_LAST) begin
                    phase <= P_IGN;
                    wp    <= in_byte[7];
                    if (!wp) begin
                      tk_wr_mask_o <= '1;
                      for (int i = 0; i < TREGS; i++) tk_wr_data_o[i*8 +: 8] <= bbuf[i];
                    end
                  end else begin
                    idx <= idx + 1'b1;
                  end
                end else begin
                  phase <= P_IGN;
                  if (idx == CLK_LAST) begin
                    wp <= in_byte[7];
                  end else if (!wp) begin
                    for (int i = 0; i < TREGS; i++)
                      if (idx == AW'(i)) begin
                        tk_wr_mask_o[i]         <= 1'b1;
                        tk_wr_data_o[i*8 +: 8]  <= in_byte;
                      end
                  end
                end
              end
            end
            default: ;
          endcase
        end
        if (sck_fall && phase == P_RD) begin
          tcnt    <= tcnt + 3'd1;
          sdio_oe <= 1'b1;
          if (tcnt == 3'd0) txsh <= rd_byte;
          else txsh <= {1'b0, txsh[7:1]};
          if (tcnt == 3'd7 && burst)
            idx <= (idx == (space ? RAM_LAST : CLK_LAST)) ? '0 : idx + 1'b1;
        end
      end
    end
endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk #(
  parameter int TREGS = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_s,
  input logic             sck_fall,
  input logic             wp,
  input logic             sdio_o,
  input logic             sdio_oe,
  input logic [TREGS-1:0] tk_wr_mask_o
);
  assert_idle_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !sdio_oe);

  assert_oe_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sck_fall));

  assert_tx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && !$past(sck_fall)) |-> $stable(sdio_o));

  assert_mask_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tk_wr_mask_o) || (&tk_wr_mask_o));

  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> (tk_wr_mask_o == '0));
endmodule

bind serial_reg_slave serial_reg_slave_chk #(.TREGS(CLK_REGS-1)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_s        (sel_s),
  .sck_fall     (sck_fall),
  .wp           (wp),
  .sdio_o       (sdio_o),
  .sdio_oe      (sdio_oe),
  .tk_wr_mask_o (tk_wr_mask_o)
);

// File: tb/test_serial_reg_slave.sv
module test_serial_reg_slave;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, sel, sck, sdi;
  logic        sdio_o, sdio_oe;
  logic [55:0] tk_time, wdata, last_data;
  logic [6:0]  mask, last_mask;
  int          checks = 0, fails = 0, pulses;
  bit          done = 0;

  serial_reg_slave i_serial_reg_slave (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .tk_time_i(tk_time),
    .tk_wr_mask_o(mask), .tk_wr_data_o(wdata));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tk_time   <= 56'h36_35_34_33_32_31_30;
      pulses    <= 0;
      last_mask <= '0;
      last_data <= '0;
    end else if (mask != '0) begin
      pulses    <= pulses + 1;
      last_mask <= mask;
      last_data <= wdata;
      for (int i = 0; i < 7; i++) if (mask[i]) tk_time[i*8 +: 8] <= wdata[i*8 +: 8];
    end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_x();
    sel = 1'b1; tick(8);
  endtask

  task automatic close_x();
    sel = 1'b0; sck = 1'b0; tick(8);
  endtask

  task automatic put_bit(logic b);
    sdi = b; tick(4); sck = 1'b1; tick(8); sck = 1'b0; tick(4);
  endtask

  task automatic put_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      tick(8);
      if (i == 0) chk("R2 oe on first read bit", sdio_oe, 1);
      b[i] = sdio_o;
      sck = 1'b1; tick(8); sck = 1'b0; tick(4);
    end
  endtask

  task automatic wr(logic [7:0] cmd, logic [7:0] d);
    open_x(); put_byte(cmd); put_byte(d); close_x();
  endtask

  task automatic rd(logic [7:0] cmd, output logic [7:0] d);
    open_x(); put_byte(cmd); get_byte(d); close_x();
  endtask

  task automatic t_reset();
    chk("R1 reset oe", sdio_oe, 0);
    chk("R5 reset mask", mask, 0);
  endtask

  task automatic t_ram_single();
    logic [7:0] d, d2;
    wr(8'hCA, 8'hA5);
    open_x(); put_byte(8'hCB); get_byte(d); get_byte(d2); close_x();
    chk("R4 ram5 readback", d, 8'hA5);
    chk("R11 repeated byte", d2, 8'hA5);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    open_x(); put_byte(8'hCC);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    close_x();
    rd(8'hCD, d);
    chk("R1 partial byte dropped", d, 8'h00);
    open_x(); put_byte(8'hCB); tick(12);
    chk("R1 driving before abort", sdio_oe, 1);
    sel = 1'b0; tick(8);
    chk("R1 hi-z after abort", sdio_oe, 0);
    close_x();
  endtask

  task automatic t_bad_cmd();
    logic [7:0] d;
    open_x(); put_byte(8'h4A); put_byte(8'h11); put_byte(8'h4B);
    tick(12);
    chk("R3 no drive on bad command", sdio_oe, 0);
    close_x();
    rd(8'hCB, d);
    chk("R3 ram5 untouched", d, 8'hA5);
  endtask

  task automatic t_clock_single();
    logic [7:0] d;
    int p = pulses;
    wr(8'h84, 8'h12);
    chk("R5 one pulse", pulses, p + 1);
    chk("R5 mask", last_mask, 7'b0000100);
    chk("R5 data lane", last_data[23:16], 8'h12);
    rd(8'h85, d);
    chk("R5 read time reg", d, 8'h12);
    rd(8'h81, d);
    chk("R5 read reg0", d, 8'h30);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    int p;
    wr(8'h8E, 8'hFF);
    rd(8'h8F, d);
    chk("R9 control low bits zero", d, 8'h80);
    wr(8'hCA, 8'h33);
    rd(8'hCB, d);
    chk("R8 ram write blocked", d, 8'hA5);
    p = pulses;
    wr(8'h84, 8'h77);
    chk("R8 clock write blocked", pulses, p);
    rd(8'h85, d);
    chk("R8 time reg unchanged", d, 8'h12);
    open_x(); put_byte(8'hBE);
    for (int i = 0; i < 8; i++) put_byte(8'h00);
    close_x();
    chk("R8 burst commit blocked", pulses, p);
    rd(8'h8F, d);
    chk("R8 control still writable", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(8'h93, d);
    chk("R10 clock addr 9", d, 8'h00);
    rd(8'hF5, d);
    chk("R10 ram addr 26", d, 8'h00);
  endtask

  task automatic t_ram_burst();
    logic [7:0] d;
    open_x(); put_byte(8'hFE);
    put_byte(8'h01); put_byte(8'h02); put_byte(8'h03);
    close_x();
    open_x(); put_byte(8'hFF);
    for (int i = 0; i < 25; i++) begin
      get_byte(d);
      if (i < 3) chk("R6 burst byte", d, 8'(i + 1));
      if (i == 5) chk("R6 byte5 kept", d, 8'hA5);
      if (i == 24) chk("R6 wrap to byte0", d, 8'h01);
    end
    close_x();
  endtask

  task automatic t_clock_burst();
    logic [7:0] d;
    logic [7:0] v [8] = '{8'h45, 8'h23, 8'h11, 8'h07, 8'h09, 8'h03, 8'h24, 8'h00};
    int p = pulses;
    open_x(); put_byte(8'hBE);
    for (int i = 0; i < 5; i++) put_byte(v[i]);
    close_x();
    chk("R7 short burst no commit", pulses, p);
    open_x(); put_byte(8'hBE);
    for (int i = 0; i < 8; i++) put_byte(v[i]);
    close_x();
    chk("R7 single commit", pulses, p + 1);
    chk("R7 full mask", last_mask, 7'h7F);
    chk("R7 commit data", last_data, 56'h24_03_09_07_11_23_45);
    open_x(); put_byte(8'hBF);
    for (int i = 0; i < 9; i++) begin
      get_byte(d);
      chk("R7 burst read", d, v[i % 8]);
    end
    close_x();
  endtask

  task automatic t_extra_write();
    logic [7:0] d;
    open_x(); put_byte(8'hCE); put_byte(8'h5A); put_byte(8'hFF); close_x();
    rd(8'hCF, d);
    chk("R12 ram7 value", d, 8'h5A);
    rd(8'hD1, d);
    chk("R12 ram8 untouched", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; sel = 1'b0; sck = 1'b0; sdi = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_ram_single();
    t_abort();
    t_bad_cmd();
    t_clock_single();
    t_protect();
    t_unmapped();
    t_ram_burst();
    t_clock_burst();
    t_extra_write();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule